// File: doc/BRIEF.md
# Shadow Stack Push/Pop Unit

This block carries out the shadow-stack instructions of a RISC-V style integer core. It owns the shadow stack pointer and executes three operations.

- A push lowers the pointer by one machine word and writes a return address there.
- A pop-check reads the word at the pointer and compares it with a return-address register. A mismatch raises a software-check trap.
- A pointer read copies the pointer to a destination register.

The core hands the unit raw instruction bits together with the current privilege mode. The unit decodes both the 32-bit forms and the two 16-bit compressed forms. Every other bit pattern completes with no effect.

Whether an operation may run depends on the privilege mode and on three shadow-stack enable bits: one each from the machine, hypervisor and supervisor environment configuration. Refusals are reported as either illegal-instruction or virtual-instruction traps, and the two classes are kept apart. Memory traffic goes through a single word-wide request port with a valid/ready handshake. While a request is outstanding, the unit reports busy and accepts no new operation.

Top module: `ssp_unit`

## Requirements
- R1: Recognised encodings are:
  - push x1 = 0xCE104073 and push x5 = 0xCE504073;
  - pop-check x1 = 0xCDC0C073 and pop-check x5 = 0xCDC2C073;
  - pointer read = 0xCDC04073 with a non-zero destination in bits 11:7;
  - when bits 1:0 are not 11, the 16-bit value 0x6081 in bits 15:0 is push x1 and 0x6281 is pop-check x5.

  Any other pattern completes (`done` pulses) with no trap, no memory access and no register write.
- R2: When `ssp_present` is 0, a recognised operation traps with cause 2 and makes no memory access. This is checked ahead of every other condition.
- R3: Privilege codes are U=000, S=001, M=011, VU=100 and VS=101. A cause-2 trap is raised when the mode is not M and the machine enable is 0, or when the mode is U and the supervisor enable is 0. This check is made before the virtual check.
- R4: A cause-22 trap is raised in VS when the hypervisor enable is 0, and in VU when the hypervisor enable or the supervisor enable is 0.
- R5: When no trap applies and all three enables are 0, the operation has no effect. Push and pop-check complete with no memory access, and pointer read writes zero to its destination.
- R6: Push writes the selected link register at address pointer − XLEN/8. The pointer takes that address only once the write is accepted; the address wraps modulo 2^XLEN.
- R7: Pop-check reads the word at the pointer. If the word equals the selected link register, the pointer grows by XLEN/8. Otherwise a cause-18 trap is raised and the pointer is left unchanged.
- R8: When the operation is permitted and any enable is 1, pointer read writes the pointer value to the destination index taken from bits 11:7.
- R9: A trap presents `trap_valid` with `trap_cause` and `trap_tval`. `trap_tval` holds the instruction bits, and a 16-bit form is zero-extended from bits 15:0.
- R10: A memory request holds its address, data and direction until `mem_ready` is seen. Operations offered while `busy` is high are ignored.
- R11: After reset:
  - the pointer is zero;
  - no request or result pulse is active.

  While idle, `ssp_wr_en` loads the pointer from `ssp_wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Instruction offered this cycle |
| op_instr | input | 32 | Raw instruction bits |
| op_priv | input | 3 | Privilege mode code |
| sse_m | input | 1 | Machine-level shadow-stack enable |
| sse_h | input | 1 | Hypervisor-level shadow-stack enable |
| sse_s | input | 1 | Supervisor-level shadow-stack enable |
| ssp_present | input | 1 | Pointer register implemented |
| link_x1 | input | XLEN | Value of x1 |
| link_x5 | input | XLEN | Value of x5 |
| ssp_wr_en | input | 1 | Pointer register write strobe |
| ssp_wr_data | input | XLEN | Pointer register write value |
| busy | output | 1 | Memory request outstanding |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | XLEN | Request address |
| mem_wdata | output | XLEN | Write data |
| mem_ready | input | 1 | Request accepted; read data valid |
| mem_rdata | input | XLEN | Read data |
| done | output | 1 | Operation completed (pulse) |
| rd_we | output | 1 | Destination register write (pulse) |
| rd_addr | output | 5 | Destination register index |
| rd_data | output | XLEN | Destination register value |
| trap_valid | output | 1 | Exception raised (pulse) |
| trap_cause | output | 6 | Exception cause |
| trap_tval | output | 32 | Faulting instruction bits |

## Verification
The bench sweeps every operation form against every privilege code, all eight enable patterns and both states of pointer presence, with varying memory wait states. It compares each outcome against an arithmetic model. If the illegal and virtual checks were taken in the wrong order, the bench would see cause 22 where cause 2 is due, for example in VS with both machine and hypervisor enables clear. A design that moved the pointer on a failed pop-check, or that stored a push before lowering the pointer, would leave a wrong pointer or a wrong memory word. The bench also targets three further cases: a push that wraps from address zero, a compressed form with garbage in its upper half, and operations held on the port while busy. A design that leaked any of these would show a wrong fault value or a second completion.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;

  localparam int unsigned CAUSE_W = 6;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 6'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_SWCHECK = 6'd18;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRTUAL = 6'd22;

  localparam logic [2:0] PRIV_U  = 3'b000;
  localparam logic [2:0] PRIV_S  = 3'b001;
  localparam logic [2:0] PRIV_M  = 3'b011;
  localparam logic [2:0] PRIV_VU = 3'b100;
  localparam logic [2:0] PRIV_VS = 3'b101;

  localparam logic [31:0] ENC_PUSH_X1 = 32'hCE10_4073;
  localparam logic [31:0] ENC_PUSH_X5 = 32'hCE50_4073;
  localparam logic [31:0] ENC_POP_X1  = 32'hCDC0_C073;
  localparam logic [31:0] ENC_POP_X5  = 32'hCDC2_C073;
  localparam logic [31:0] ENC_RDP_MSK = 32'hFFFF_F07F;
  localparam logic [31:0] ENC_RDP_VAL = 32'hCDC0_4073;
  localparam logic [15:0] ENC_C_PUSH  = 16'h6081;
  localparam logic [15:0] ENC_C_POP   = 16'h6281;

  typedef enum logic [1:0] {SOP_NONE, SOP_PUSH, SOP_POPCHK, SOP_RDPTR} sop_e;

  typedef enum logic [2:0] {GT_UNIMPL, GT_ILLEGAL, GT_VIRTUAL, GT_OFF, GT_ON} gate_e;

  typedef struct packed {
    sop_e       op;
    logic       use_x5;
    logic [4:0] rd;
  } sdec_t;

endpackage

// File: rtl/ssp_decode.sv
`timescale 1ns/1ps
module ssp_decode
  import ssp_pkg::*;
(
  input  logic [31:0] instr,
  output sdec_t       dec,
  output logic        is_short
);

  always_comb begin
    dec.op     = SOP_NONE;
    dec.use_x5 = 1'b0;
    dec.rd     = 5'd0;
    is_short   = (instr[1:0] != 2'b11);
    if (is_short) begin
      if (instr[15:0] == ENC_C_PUSH) begin
        dec.op = SOP_PUSH;
      end else if (instr[15:0] == ENC_C_POP) begin
        dec.op     = SOP_POPCHK;
        dec.use_x5 = 1'b1;
      end
    end else begin
      if (instr == ENC_PUSH_X1) begin
        dec.op = SOP_PUSH;
      end else if (instr == ENC_PUSH_X5) begin
        dec.op     = SOP_PUSH;
        dec.use_x5 = 1'b1;
      end else if (instr == ENC_POP_X1) begin
        dec.op = SOP_POPCHK;
      end else if (instr == ENC_POP_X5) begin
        dec.op     = SOP_POPCHK;
        dec.use_x5 = 1'b1;
      end else if (((instr & ENC_RDP_MSK) == ENC_RDP_VAL) && (instr[11:7] != 5'd0)) begin
        dec.op = SOP_RDPTR;
        dec.rd = instr[11:7];
      end
    end
  end

endmodule

// File: rtl/ssp_gate.sv
`timescale 1ns/1ps
module ssp_gate
  import ssp_pkg::*;
(
  input  logic [2:0] priv,
  input  logic       sse_m,
  input  logic       sse_h,
  input  logic       sse_s,
  input  logic       present,
  output gate_e      outcome
);

  logic in_m, in_u, in_vs, in_vu;
  logic deny_ill, deny_virt;

  always_comb begin
    in_m  = (priv == PRIV_M);
    in_u  = (priv == PRIV_U);
    in_vs = (priv == PRIV_VS);
    in_vu = (priv == PRIV_VU);
    deny_ill  = (!in_m && !sse_m) || (in_u && !sse_s);
    deny_virt = (in_vs && !sse_h) || (in_vu && (!sse_h || !sse_s));
    if (!present)                    outcome = GT_UNIMPL;
    else if (deny_ill)               outcome = GT_ILLEGAL;
    else if (deny_virt)              outcome = GT_VIRTUAL;
    else if (sse_m | sse_h | sse_s)  outcome = GT_ON;
    else                             outcome = GT_OFF;
  end

endmodule

// File: rtl/ssp_unit.sv
`timescale 1ns/1ps
module ssp_unit
  import ssp_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [31:0]        op_instr,
  input  logic [2:0]         op_priv,
  input  logic               sse_m,
  input  logic               sse_h,
  input  logic               sse_s,
  input  logic               ssp_present,
  input  logic [XLEN-1:0]    link_x1,
  input  logic [XLEN-1:0]    link_x5,
  input  logic               ssp_wr_en,
  input  logic [XLEN-1:0]    ssp_wr_data,
  output logic               busy,
  output logic               mem_req,
  output logic               mem_we,
  output logic [XLEN-1:0]    mem_addr,
  output logic [XLEN-1:0]    mem_wdata,
  input  logic               mem_ready,
  input  logic [XLEN-1:0]    mem_rdata,
  output logic               done,
  output logic               rd_we,
  output logic [4:0]         rd_addr,
  output logic [XLEN-1:0]    rd_data,
  output logic               trap_valid,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [31:0]        trap_tval
);

  localparam int unsigned      WORD_BYTES = XLEN / 8;
  localparam logic [XLEN-1:0]  STEP       = XLEN'(WORD_BYTES);

  typedef enum logic {ST_IDLE, ST_MEM} st_e;

  sdec_t dec;
  logic  is_short;
  gate_e gate;

  ssp_decode u_dec (.instr(op_instr), .dec(dec), .is_short(is_short));

  ssp_gate u_gate (
    .priv(op_priv), .sse_m(sse_m), .sse_h(sse_h), .sse_s(sse_s),
    .present(ssp_present), .outcome(gate)
  );

  st_e               st_q, st_d;
  logic [XLEN-1:0]   ptr_q, ptr_d;
  logic              ptr_en;
  logic              rq_en;
  logic              rq_we_q, rq_we_d;
  logic [XLEN-1:0]   rq_addr_q, rq_addr_d;
  logic [XLEN-1:0]   rq_data_q, rq_data_d;
  logic [31:0]       ins_q, ins_d;
  logic              done_q, done_d;
  logic              trap_q, trap_d;
  logic              rdwe_q, rdwe_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic [31:0]       tval_q, tval_d;
  logic [4:0]        rdaddr_q, rdaddr_d;
  logic [XLEN-1:0]   rddata_q, rddata_d;
  logic [XLEN-1:0]   link_sel;
  logic [31:0]       ins_ext;

  // next-state logic
  always_comb begin
    st_d      = st_q;
    ptr_d     = ptr_q;
    ptr_en    = 1'b0;
    rq_en     = 1'b0;
    rq_we_d   = rq_we_q;
    rq_addr_d = rq_addr_q;
    rq_data_d = rq_data_q;
    ins_d     = ins_q;
    done_d    = 1'b0;
    trap_d    = 1'b0;
    rdwe_d    = 1'b0;
    cause_d   = cause_q;
    tval_d    = tval_q;
    rdaddr_d  = rdaddr_q;
    rddata_d  = rddata_q;
    link_sel  = dec.use_x5 ? link_x5 : link_x1;
    ins_ext   = is_short ? {16'h0000, op_instr[15:0]} : op_instr;

    unique case (st_q)
      ST_IDLE: begin
        if (ssp_wr_en) begin
          ptr_d  = ssp_wr_data;
          ptr_en = 1'b1;
        end
        if (op_valid) begin
          tval_d = ins_ext;
          if (dec.op == SOP_NONE) begin
            done_d = 1'b1;
          end else begin
            unique case (gate)
              GT_UNIMPL, GT_ILLEGAL: begin
                done_d  = 1'b1;
                trap_d  = 1'b1;
                cause_d = CAUSE_ILLEGAL;
              end
              GT_VIRTUAL: begin
                done_d  = 1'b1;
                trap_d  = 1'b1;
                cause_d = CAUSE_VIRTUAL;
              end
              GT_OFF: begin
                done_d = 1'b1;
                if (dec.op == SOP_RDPTR) begin
                  rdwe_d   = 1'b1;
                  rdaddr_d = dec.rd;
                  rddata_d = '0;
                end
              end
              default: begin
                if (dec.op == SOP_RDPTR) begin
                  done_d   = 1'b1;
                  rdwe_d   = 1'b1;
                  rdaddr_d = dec.rd;
                  rddata_d = ptr_q;
                end else begin
                  st_d      = ST_MEM;
                  rq_en     = 1'b1;
                  rq_we_d   = (dec.op == SOP_PUSH);
                  rq_addr_d = (dec.op == SOP_PUSH) ? (ptr_q - STEP) : ptr_q;
                  rq_data_d = link_sel;
                  ins_d     = ins_ext;
                end
              end
            endcase
          end
        end
      end
      ST_MEM: begin
        if (mem_ready) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          if (rq_we_q) begin
            ptr_d  = rq_addr_q;
            ptr_en = 1'b1;
          end else if (mem_rdata == rq_data_q) begin
            ptr_d  = rq_addr_q + STEP;
            ptr_en = 1'b1;
          end else begin
            trap_d  = 1'b1;
            cause_d = CAUSE_SWCHECK;
            tval_d  = ins_q;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      trap_q <= 1'b0;
      rdwe_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      trap_q <= trap_d;
      rdwe_q <= rdwe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_we_q   <= 1'b0;
      rq_addr_q <= '0;
      rq_data_q <= '0;
      ins_q     <= '0;
    end else if (rq_en) begin
      rq_we_q   <= rq_we_d;
      rq_addr_q <= rq_addr_d;
      rq_data_q <= rq_data_d;
      ins_q     <= ins_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q  <= '0;
      tval_q   <= '0;
      rdaddr_q <= '0;
      rddata_q <= '0;
    end else if (done_d) begin
      cause_q  <= cause_d;
      tval_q   <= tval_d;
      rdaddr_q <= rdaddr_d;
      rddata_q <= rddata_d;
    end
  end

  assign busy       = (st_q == ST_MEM);
  assign mem_req    = (st_q == ST_MEM);
  assign mem_we     = rq_we_q;
  assign mem_addr   = rq_addr_q;
  assign mem_wdata  = rq_data_q;
  assign done       = done_q;
  assign trap_valid = trap_q;
  assign trap_cause = cause_q;
  assign trap_tval  = tval_q;
  assign rd_we      = rdwe_q;
  assign rd_addr    = rdaddr_q;
  assign rd_data    = rddata_q;

  // R3: a virtual trap implies the illegal check already passed
  a_r3_ill_first: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && gate == GT_VIRTUAL) |-> (sse_m && ssp_present));

  // R2/R5: refused or disabled operations never start a memory request
  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && gate != GT_ON) |=> !mem_req);

  // R6: a push targets one word below the current pointer
  a_r6_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == ptr_q - STEP));

  // R6: the pointer takes the push address once the write is accepted
  a_r6_push_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && mem_we) |=> (ptr_q == $past(mem_addr)));

  // R7: a mismatch traps with the software-check cause and leaves the pointer
  a_r7_mismatch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !mem_we && mem_rdata != mem_wdata)
    |=> (trap_valid && trap_cause == CAUSE_SWCHECK && $stable(ptr_q)));

  // R10: an unaccepted request holds still
  a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready)
    |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R9: a trap never coincides with a register write
  a_r9_trap_excl: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (!rd_we && done));

endmodule

// File: tb/ssp_unit_bench.sv
`timescale 1ns/1ps
module ssp_unit_bench;
  import ssp_pkg::*;

  localparam int unsigned W = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, op_valid, sse_m, sse_h, sse_s, ssp_present, ssp_wr_en;
  logic [31:0] op_instr;
  logic [2:0] op_priv;
  logic [W-1:0] link_x1, link_x5, ssp_wr_data;
  logic busy, mem_req, mem_we, mem_ready, done, rd_we, trap_valid;
  logic [W-1:0] mem_addr, mem_wdata, mem_rdata, rd_data;
  logic [4:0] rd_addr;
  logic [5:0] trap_cause;
  logic [31:0] trap_tval;

  ssp_unit #(.XLEN(W)) u_ssp_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_instr(op_instr),
    .op_priv(op_priv), .sse_m(sse_m), .sse_h(sse_h), .sse_s(sse_s),
    .ssp_present(ssp_present), .link_x1(link_x1), .link_x5(link_x5),
    .ssp_wr_en(ssp_wr_en), .ssp_wr_data(ssp_wr_data), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .done(done), .rd_we(rd_we), .rd_addr(rd_addr), .rd_data(rd_data),
    .trap_valid(trap_valid), .trap_cause(trap_cause), .trap_tval(trap_tval)
  );

  logic [31:0] mem [0:255];
  int unsigned gap = 0;
  int unsigned wcnt = 0;
  int n_hs = 0, n_done = 0, n_rdwe = 0;
  logic pk_en = 1'b0;
  logic [7:0] pk_idx = 8'd0;
  logic [31:0] pk_val = 32'd0;

  assign mem_ready = mem_req && (wcnt >= gap);
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (mem_req && !mem_ready) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (mem_req && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    else if (pk_en) mem[pk_idx] <= pk_val;
    if (mem_req && mem_ready) n_hs <= n_hs + 1;
    if (done) n_done <= n_done + 1;
    if (rd_we) n_rdwe <= n_rdwe + 1;
  end

  int n_tests = 0, n_fail = 0;
  logic r_seen, r_trap, r_rdwe;
  logic [5:0] r_cause;
  logic [31:0] r_tval, r_rdata;
  logic [4:0] r_rdaddr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] idx, input logic [31:0] val);
    pk_en = 1'b1; pk_idx = idx; pk_val = val;
    @(negedge clk);
    pk_en = 1'b0;
  endtask

  task automatic set_ptr(input logic [31:0] v);
    ssp_wr_en = 1'b1; ssp_wr_data = v;
    @(negedge clk);
    ssp_wr_en = 1'b0;
  endtask

  task automatic run_op(input logic [31:0] ins, input logic [2:0] pv,
                        input logic [2:0] sse, input logic cp);
    op_instr = ins; op_priv = pv;
    sse_m = sse[2]; sse_h = sse[1]; sse_s = sse[0]; ssp_present = cp;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    r_seen = 1'b0;
    for (int k = 0; k < 64; k++) begin
      if (done) begin
        r_seen = 1'b1; r_trap = trap_valid; r_cause = trap_cause;
        r_tval = trap_tval; r_rdwe = rd_we; r_rdata = rd_data; r_rdaddr = rd_addr;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic read_ptr(output logic [31:0] v);
    run_op(32'hCDC0_44F3, PRIV_M, 3'b100, 1'b1);
    v = r_rdata;
  endtask

  logic [31:0] ops [0:6];
  logic [2:0]  privs [0:4];

  initial begin
    ops[0] = 32'hCE10_4073; ops[1] = 32'hCE50_4073; ops[2] = 32'h0000_6081;
    ops[3] = 32'hCDC0_C073; ops[4] = 32'hCDC2_C073; ops[5] = 32'h0000_6281;
    ops[6] = 32'hCDC0_43F3;
    privs[0] = PRIV_U; privs[1] = PRIV_S; privs[2] = PRIV_M;
    privs[3] = PRIV_VU; privs[4] = PRIV_VS;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] p, lnk, x1v, x5v;
    int hs0, d0, w0, cls, idx;
    bit is_push, is_pop, mism, m_m, m_u, m_vs, m_vu;
    rst_n = 1'b0; op_valid = 1'b0; op_instr = '0; op_priv = PRIV_M;
    sse_m = 0; sse_h = 0; sse_s = 0; ssp_present = 1; ssp_wr_en = 0;
    ssp_wr_data = '0; link_x1 = '0; link_x5 = '0;
    for (int a = 0; a < 256; a++) mem[a] = 32'h0;
    repeat (3) @(negedge clk);
    chk("R11 reset mem_req", {31'd0, mem_req}, 32'd0);
    chk("R11 reset busy", {31'd0, busy}, 32'd0);
    chk("R11 reset done/trap", {30'd0, done, trap_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    read_ptr(p);
    chk("R11 reset pointer", p, 32'd0);
    set_ptr(32'h0000_1234);
    read_ptr(p);
    chk("R11 pointer write port", p, 32'h0000_1234);

    // main sweep: operation x privilege x enables x presence
    idx = 0;
    for (int oi = 0; oi < 7; oi++)
      for (int pi = 0; pi < 5; pi++)
        for (int s = 0; s < 8; s++)
          for (int c = 0; c < 2; c++) begin
            gap = idx % 4;
            x1v = 32'h1100_0000 + idx; x5v = 32'h5500_0000 + idx;
            link_x1 = x1v; link_x5 = x5v;
            is_push = (oi < 3); is_pop = (oi >= 3 && oi < 6);
            lnk = (oi == 1 || oi == 4 || oi == 5) ? x5v : x1v;
            mism = (idx % 3 == 0);
            set_ptr(32'h80);
            poke(8'h20, is_pop ? (mism ? (lnk ^ 32'h100) : lnk) : 32'h0);
            poke(8'h1F, 32'h0);
            hs0 = n_hs;
            run_op(ops[oi], privs[pi], s[2:0], c[0]);
            m_m = (privs[pi] == PRIV_M); m_u = (privs[pi] == PRIV_U);
            m_vs = (privs[pi] == PRIV_VS); m_vu = (privs[pi] == PRIV_VU);
            if (c == 0) cls = 0;
            else if ((!m_m && !s[2]) || (m_u && !s[0])) cls = 0;
            else if ((m_vs && !s[1]) || (m_vu && (!s[1] || !s[0]))) cls = 1;
            else if (s == 0) cls = 2;
            else cls = 3;
            chk("R10 completion seen", {31'd0, r_seen}, 32'd1);
            if (cls == 0 || cls == 1) begin
              chk("R2/R3/R4 trap raised", {31'd0, r_trap}, 32'd1);
              chk(cls == 0 ? "R3 cause illegal" : "R4 cause virtual",
                  {26'd0, r_cause}, cls == 0 ? 32'd2 : 32'd22);
              chk("R9 trap value", r_tval, ops[oi]);
              chk("R2 no memory on trap", n_hs - hs0, 32'd0);
              chk("R9 no write on trap", {31'd0, r_rdwe}, 32'd0);
            end else if (cls == 2) begin
              chk("R5 no trap when off", {31'd0, r_trap}, 32'd0);
              chk("R5 no memory when off", n_hs - hs0, 32'd0);
              if (oi == 6) begin
                chk("R5 rdptr writes", {31'd0, r_rdwe}, 32'd1);
                chk("R5 rdptr zero", r_rdata, 32'd0);
              end
            end else begin
              if (is_push) begin
                chk("R6 push one access", n_hs - hs0, 32'd1);
                chk("R6 push no trap", {31'd0, r_trap}, 32'd0);
                @(negedge clk);
                chk("R6 push stored word", mem[8'h1F], lnk);
              end else if (is_pop) begin
                chk("R7 pop one access", n_hs - hs0, 32'd1);
                chk("R7 pop trap on mismatch", {31'd0, r_trap}, {31'd0, mism});
                if (mism) begin
                  chk("R7 cause swcheck", {26'd0, r_cause}, 32'd18);
                  chk("R9 pop trap value", r_tval, ops[oi]);
                end
              end else begin
                chk("R8 rdptr writes", {31'd0, r_rdwe}, 32'd1);
                chk("R8 rdptr value", r_rdata, 32'h80);
                chk("R8 rdptr index", {27'd0, r_rdaddr}, 32'd7);
              end
            end
            read_ptr(p);
            if (cls == 3 && is_push) chk("R6 pointer lowered", p, 32'h7C);
            else if (cls == 3 && is_pop && !mism) chk("R7 pointer raised", p, 32'h84);
            else chk("R7/R2 pointer unchanged", p, 32'h80);
            idx++;
          end

    // R1: unrecognised patterns are no-ops
    gap = 0;
    set_ptr(32'h80);
    foreach (ops[j]) if (j < 0) ;
    for (int q = 0; q < 2; q++) begin
      hs0 = n_hs; w0 = n_rdwe;
      run_op(q == 0 ? 32'h0000_6181 : 32'hCDC1_4073, PRIV_M, 3'b111, 1'b1);
      chk("R1 unknown completes", {31'd0, r_seen}, 32'd1);
      chk("R1 unknown no trap", {31'd0, r_trap}, 32'd0);
      chk("R1 unknown no memory", n_hs - hs0, 32'd0);
      chk("R1 unknown no write", n_rdwe - w0, 32'd0);
    end
    read_ptr(p);
    chk("R1 unknown pointer kept", p, 32'h80);

    // R6: push wraps below address zero
    link_x1 = 32'hCAFE_0001;
    set_ptr(32'h0);
    run_op(32'hCE10_4073, PRIV_S, 3'b100, 1'b1);
    @(negedge clk);
    chk("R6 wrap stored word", mem[8'hFF], 32'hCAFE_0001);
    read_ptr(p);
    chk("R6 wrap pointer", p, 32'hFFFF_FFFC);

    // R6/R7: push then compressed pop-check round trip
    gap = 2;
    link_x5 = 32'h0BAD_F00D;
    set_ptr(32'h100);
    run_op(32'hCE50_4073, PRIV_VS, 3'b111, 1'b1);
    run_op(32'h0000_6281, PRIV_VU, 3'b111, 1'b1);
    chk("R7 round trip no trap", {31'd0, r_trap}, 32'd0);
    read_ptr(p);
    chk("R7 round trip pointer", p, 32'h100);

    // R9: compressed form with garbage upper half
    run_op(32'hABCD_6081, PRIV_S, 3'b000, 1'b1);
    chk("R9 short trap cause", {26'd0, r_cause}, 32'd2);
    chk("R9 short trap value", r_tval, 32'h0000_6081);

    // R10: operations offered while busy are ignored
    gap = 6;
    link_x1 = 32'h7777_0000;
    set_ptr(32'h40);
    poke(8'h10, 32'h7777_0000);
    d0 = n_done; w0 = n_rdwe;
    op_instr = 32'hCDC0_C073; op_priv = PRIV_M; sse_m = 1; sse_h = 0; sse_s = 0;
    ssp_present = 1; op_valid = 1'b1;
    @(negedge clk);
    op_instr = 32'hCDC0_44F3;
    repeat (3) @(negedge clk);
    op_valid = 1'b0;
    repeat (12) @(negedge clk);
    chk("R10 single completion while busy", n_done - d0, 32'd1);
    chk("R10 held op not executed", n_rdwe - w0, 32'd0);
    gap = 0;
    read_ptr(p);
    chk("R10 pointer after busy pop", p, 32'h44);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule